// File: doc/BRIEF.md
# Serial memory command frame decoder

This block is the slave-side command front end of a buffered serial memory device. It watches a serial clock, an active-low chip select and a data input, all synchronous to the system clock `clk`. It assembles a fixed-format command frame. The frame starts with an 8-bit opcode. Three 16-bit fields follow, and then 16 control clocks that carry no data. Two opcodes are decoded: a program-buffer-to-SRAM transfer and a configuration register read.

For the configuration read, the block drives data on `so` once the frame is complete. It first sends a 16-bit ready/busy status word, then a 16-bit configuration word. Only the low nine bits of the configuration word hold register content.

For the transfer, nothing happens until chip select returns high. At that point, if the frame was complete and valid and the device is not busy, a one-cycle start pulse goes to the transfer engine. Any frame that is cut short, carries a nonzero field or has an unknown opcode is dropped with no effect.

Top module: `sermem_cmd_front`

## Requirements
- R1: After reset, `so_oe` and `xfer_start` are 0.
- R2: For opcode 8BH with all three fields zero, the block drives 32 bits on `so` after the 72nd rising serial clock. The order is the 16-bit `rb_status` word, then the configuration word, each MSB first. A new bit is launched on every falling serial clock edge, so the master samples bit n before rising edge 72+n.
- R3: Configuration word bits 8:0 equal `cfg_bits` and bits 15:9 read as zero.
- R4: `so_oe` is 1 only while the 32 read bits are presented. It is 0 during the command and field phases, after the last bit, and while chip select is high.
- R5: For opcode 55H with all fields zero and at least 72 rising clocks, `xfer_start` pulses high for exactly one `clk` cycle after chip select rises, and never while chip select is low.
- R6: A transfer frame is ignored when `busy` is 1 at the chip select rise.
- R7: A frame whose chip select rises before 72 rising serial clocks have been seen produces no pulse and no read data.
- R8: A frame with any nonzero bit in the three 16-bit fields produces no pulse and no read data.
- R9: Opcodes other than 55H and 8BH produce no pulse and no read data. The data on `si` during the 16 control clocks has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, idle low, synchronous to clk |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in, sampled on rising sck |
| busy | input | 1 | Device busy flag, blocks the transfer |
| rb_status | input | 16 | Ready/busy status word sent before config data |
| cfg_bits | input | 9 | Configuration register content |
| so | output | 1 | Serial data out, changes on falling sck |
| so_oe | output | 1 | Output enable for so |
| xfer_start | output | 1 | One-cycle start pulse to the transfer engine |

## Verification
The bench targets the frame length boundaries. These are a transfer cut off after 71 clocks, which must not start, and one with exactly 72 clocks, which must start. A design with an off-by-one counter would fire on the short frame or miss the exact one. A nonzero bit in the last field position checks that the whole 48-bit field range is watched. All-ones status and configuration inputs would show up any leakage into the reserved bits. Extra clocks after the 32nd read bit check that the output enable is released and that a data path which keeps shifting is caught.

// File: rtl/sermem_cmd_front.sv
module sermem_cmd_front #(
  parameter logic [7:0] OP_XFER   = 8'h55,
  parameter logic [7:0] OP_CFG_RD = 8'h8B,
  parameter int         CFG_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             si,
  input  logic             busy,
  input  logic [15:0]      rb_status,
  input  logic [CFG_W-1:0] cfg_bits,
  output logic             so,
  output logic             so_oe,
  output logic             xfer_start
);
  localparam int OPC_BITS   = 8;
  localparam int FIELD_BITS = 48;
  localparam int CTRL_BITS  = 16;
  localparam int WORD_BITS  = 16;
  localparam int OUT_BITS   = 2 * WORD_BITS;
  localparam int HDR_END    = OPC_BITS + FIELD_BITS;
  localparam int FRAME_BITS = HDR_END + CTRL_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS + OUT_BITS + 2);
  localparam int OCNT_W     = $clog2(OUT_BITS + 1);

  localparam logic [CNT_W-1:0]  C_OPC   = CNT_W'(OPC_BITS);
  localparam logic [CNT_W-1:0]  C_HDR   = CNT_W'(HDR_END);
  localparam logic [CNT_W-1:0]  C_FULL  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0]  C_LAST  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0]  C_MAX   = {CNT_W{1'b1}};
  localparam logic [OCNT_W-1:0] C_OUT   = OCNT_W'(OUT_BITS);

  logic                 sck_q, cs_q;
  logic [CNT_W-1:0]     cnt;
  logic [OCNT_W-1:0]    ocnt;
  logic [OPC_BITS-1:0]  opc;
  logic                 field_nz;
  logic [OUT_BITS-1:0]  oshr;

  wire sck_rise = sck & ~sck_q;
  wire sck_fall = ~sck & sck_q;
  wire cs_rise  = cs_n & ~cs_q;
  wire full     = cnt >= C_FULL;
  wire rd_ok    = (opc == OP_CFG_RD) & ~field_nz;
  wire xfer_ok  = (opc == OP_XFER) & ~field_nz & full & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q      <= 1'b0;
      cs_q       <= 1'b1;
      cnt        <= '0;
      ocnt       <= '0;
      opc        <= '0;
      field_nz   <= 1'b0;
      oshr       <= '0;
      so         <= 1'b0;
      so_oe      <= 1'b0;
      xfer_start <= 1'b0;
    end else begin
      sck_q      <= sck;
      cs_q       <= cs_n;
      xfer_start <= 1'b0;
      if (cs_n) begin
        cnt      <= '0;
        ocnt     <= '0;
        opc      <= '0;
        field_nz <= 1'b0;
        so       <= 1'b0;
        so_oe    <= 1'b0;
        if (cs_rise && xfer_ok) xfer_start <= 1'b1;
      end else begin
        if (sck_rise) begin
          if (cnt != C_MAX) cnt <= cnt + 1'b1;
          if (cnt < C_OPC) opc <= {opc[OPC_BITS-2:0], si};
          else if (cnt < C_HDR && si) field_nz <= 1'b1;
          if (cnt == C_LAST)
            oshr <= {rb_status, {(WORD_BITS-CFG_W){1'b0}}, cfg_bits};
        end
        if (sck_fall && full && rd_ok) begin
          if (ocnt < C_OUT) begin
            so    <= oshr[OUT_BITS-1];
            oshr  <= {oshr[OUT_BITS-2:0], 1'b0};
            ocnt  <= ocnt + 1'b1;
            so_oe <= 1'b1;
          end else begin
            so_oe <= 1'b0;
          end
        end
      end
    end
  end
endmodule

module sermem_cmd_front_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic cs_n,
  input logic busy,
  input logic so,
  input logic so_oe,
  input logic xfer_start
);
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !so_oe && !xfer_start);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  a_r5_pulse_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> cs_n);

  a_r6_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !$past(busy));

  a_r4_oe_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) |-> !so_oe);

  a_r2_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe && $past(so_oe) && !$stable(so) |-> !$past(sck) && $past(sck, 2));
endmodule

bind sermem_cmd_front sermem_cmd_front_chk chk_i (.*);

// File: tb/sermem_cmd_front_tb.sv
module sermem_cmd_front_tb_top;
  localparam int CLK_PER  = 10;
  localparam int HALF_SCK = 4;
  localparam int FRAME    = 72;
  localparam int RD_LAST  = FRAME + 32;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0, busy = 1'b0;
  logic [15:0] rb_status = '0;
  logic [8:0]  cfg_bits = '0;
  logic so, so_oe, xfer_start;

  int n_vec = 0, n_bad = 0, pulses = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  sermem_cmd_front dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .busy(busy),
    .rb_status(rb_status), .cfg_bits(cfg_bits),
    .so(so), .so_oe(so_oe), .xfer_start(xfer_start)
  );

  always @(posedge clk) if (xfer_start) pulses <= pulses + 1;

  function automatic bit exp_rd(input logic [7:0] op, input logic [47:0] f);
    return op == 8'h8B && f == '0;
  endfunction

  function automatic int exp_pulses(input logic [7:0] op, input logic [47:0] f,
                                    input int nrise, input bit bsy);
    return (op == 8'h55 && f == '0 && nrise >= FRAME && !bsy) ? 1 : 0;
  endfunction

  task automatic run_frame(input logic [7:0] op, input logic [47:0] f, input int nrise,
                           input bit bsy, input logic [15:0] rb, input logic [8:0] cfg,
                           input string tag);
    logic [71:0] tx;
    logic [31:0] rdata;
    bit rd, bad;
    int pexp;
    string msg;
    tx    = {op, f, 16'($urandom)};
    rd    = exp_rd(op, f);
    rdata = {rb, 7'b0, cfg};
    pexp  = exp_pulses(op, f, nrise, bsy);
    bad   = 1'b0;
    busy = bsy; rb_status = rb; cfg_bits = cfg;
    @(negedge clk);
    pulses = 0;
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 1; k <= nrise; k++) begin
      si = (k <= FRAME) ? tx[FRAME-k] : 1'($urandom);
      repeat (HALF_SCK) @(negedge clk);
      if (!bad) begin
        logic eoe, eso;
        eoe = rd && k > FRAME && k <= RD_LAST;
        eso = eoe ? rdata[RD_LAST-k] : 1'b0;
        if (so_oe !== eoe || (eoe && so !== eso)) begin
          bad = 1'b1;
          $sformat(msg, "before rise %0d oe=%0b so=%0b expected oe=%0b so=%0b",
                   k, so_oe, so, eoe, eso);
        end
      end
      sck = 1'b1;
      repeat (HALF_SCK) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF_SCK) @(negedge clk);
    if (pulses != 0 && !bad) begin
      bad = 1'b1;
      $sformat(msg, "pulse while selected got %0d expected 0", pulses);
    end
    n_vec++;
    if (bad) begin
      n_bad++;
      $display("FAIL %s data/oe: %s", tag, msg);
    end
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    n_vec++;
    if (pulses != pexp || so_oe !== 1'b0) begin
      n_bad++;
      $display("FAIL %s start pulses=%0d oe=%0b expected pulses=%0d oe=0",
               tag, pulses, so_oe, pexp);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    n_vec++;
    if (so_oe !== 1'b0 || xfer_start !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset oe=%0b start=%0b expected 0 0", so_oe, xfer_start);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_frame(8'h8B, '0, RD_LAST, 1'b0, 16'hA5C3, 9'h12D, "R2 read");
    run_frame(8'h8B, '0, RD_LAST + 6, 1'b1, 16'hFFFF, 9'h1FF, "R3 R4 read ones");
    run_frame(8'h55, '0, FRAME, 1'b0, 16'h0, 9'h0, "R5 transfer exact");
    run_frame(8'h55, '0, FRAME + 8, 1'b0, 16'h0, 9'h0, "R5 transfer long");
    run_frame(8'h55, '0, FRAME, 1'b1, 16'h0, 9'h0, "R6 transfer busy");
    run_frame(8'h55, '0, FRAME - 1, 1'b0, 16'h0, 9'h0, "R7 transfer short");
    run_frame(8'h8B, '0, 60, 1'b0, 16'h1234, 9'h0AA, "R7 read short");
    run_frame(8'h55, 48'h1, FRAME, 1'b0, 16'h0, 9'h0, "R8 transfer field");
    run_frame(8'h8B, 48'h8000_0000_0000, RD_LAST, 1'b0, 16'h5A5A, 9'h155, "R8 read field");
    run_frame(8'h54, '0, RD_LAST, 1'b0, 16'hBEEF, 9'h0F0, "R9 other opcode");
    run_frame(8'h8A, '0, RD_LAST, 1'b0, 16'hBEEF, 9'h0F0, "R9 near opcode");

    for (int i = 0; i < 40; i++) begin
      logic [7:0] op;
      logic [47:0] f;
      int nr;
      case ($urandom % 4)
        0, 3:    op = 8'h55;
        1:       op = 8'h8B;
        default: op = 8'($urandom);
      endcase
      f  = ($urandom % 4 == 0) ? {16'($urandom), 32'($urandom)} : '0;
      nr = ($urandom % 5 == 0) ? int'($urandom % FRAME) : FRAME + int'($urandom % 40);
      run_frame(op, f, nr, ($urandom % 3) == 0, 16'($urandom), 9'($urandom),
                "R2 R5 R7 R8 R9 random");
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule